// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer whose write side and read side each run on their own free-running clock. Words of `DATA_W` bits (nine by default) go in on the write clock and come out, in order, through a registered output on the read clock. The storage depth is `2**ADDR_W` words (64 by default). Four active-low status outputs report the fill level. Two of them are exact boundary flags, empty and full. The other two are threshold flags, "nearly empty" and "nearly full", and each one compares against an offset that software can load.

The write port has a primary active-low enable and a second pin whose role is fixed while reset is held. If that pin is high during reset, it acts as an active-high second write enable. If it is low during reset, it becomes an active-low strobe that loads the threshold offsets from the data bus in place of a memory write. Successive loads alternate between the two offsets, starting with the nearly-empty offset. The read port has two active-low enables and an active-low output enable. When the output enable is inactive, the data bus reads as zero. A separate valid output marks the cycle that follows each accepted read.

Pointers cross between the clock domains as Gray code through two-stage synchronizers. Each flag is registered in the domain that uses it, so full and the nearly-full flag change only on write-clock edges, and empty and the nearly-empty flag change only on read-clock edges. A single active-low reset is sampled synchronously in both domains, and it must be held for several edges of the slower clock. `ADDR_W` must not exceed `DATA_W`.

Top module: `dcfifo_progflag`

## Requirements
- R1: A word is stored on a rising `wr_clk` edge when `wr_en1_n` is 0, `wr_en2_ld` is 1 and `full_n` is 1. Stored words leave in the order they were stored.
- R2: A word is read on a rising `rd_clk` edge when `rd_en1_n` and `rd_en2_n` are both 0 and `empty_n` is 1. The word appears on `rd_data` after that edge, with `rd_valid` = 1 for exactly that one cycle. `rd_data` holds its value until the next read.
- R3: If `wr_en2_ld` is 1 during reset, it serves as a second write enable afterwards, and an edge with `wr_en1_n` = 0 and `wr_en2_ld` = 0 stores nothing.
- R4: If `wr_en2_ld` is 0 during reset, an edge with `wr_en1_n` = 0 and `wr_en2_ld` = 0 loads `wr_data[ADDR_W-1:0]` into an offset register and not into memory. The first such load sets the nearly-empty offset, the second sets the nearly-full offset, and later loads keep alternating in that order.
- R5: After reset: `empty_n` = 0, `almost_empty_n` = 0, `full_n` = 1, `almost_full_n` = 1, `rd_valid` = 0, `rd_data` = 0, and both offsets equal `DEF_OFS` (7).
- R6: `full_n` is 0 while `2**ADDR_W` words are stored. It changes only on `wr_clk` edges, and write attempts while it is 0 store nothing.
- R7: `empty_n` is 0 while no word is stored. It changes only on `rd_clk` edges, and read attempts while it is 0 leave `rd_valid` at 0.
- R8: `almost_full_n` is 0 while the free locations number at most the nearly-full offset, and 1 once they exceed it. It is updated on `wr_clk` edges.
- R9: `almost_empty_n` is 0 while the stored words number at most the nearly-empty offset, and 1 once they exceed it. It is updated on `rd_clk` edges.
- R10: While `out_en_n` is 1, `rd_data` reads 0. Reads still take place and consume words, and the held word becomes visible again when `out_en_n` returns to 0.
- R11: `empty_n` = 0 implies `almost_empty_n` = 0, and `full_n` = 0 implies `almost_full_n` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both domains |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Second write enable (active high) or offset-load strobe (active low), chosen at reset |
| wr_data | input | DATA_W | Write data; low `ADDR_W` bits carry offset values during loads |
| rd_en1_n | input | 1 | Read enable 1, active low |
| rd_en2_n | input | 1 | Read enable 2, active low |
| out_en_n | input | 1 | Output enable, active low; when inactive, `rd_data` is zero |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | High for the cycle after an accepted read |
| empty_n | output | 1 | Low when empty |
| full_n | output | 1 | Low when full |
| almost_empty_n | output | 1 | Low when the stored count is at or below the nearly-empty offset |
| almost_full_n | output | 1 | Low when the free count is at or below the nearly-full offset |

## Verification
On every edge, the assertions check that a full flag freezes the write pointer and an empty flag freezes the read pointer. They also check that each Gray pointer changes by at most one bit per edge, that the occupancy seen from either side never exceeds the depth, and that each boundary flag implies its threshold flag. What only the scenarios can show is the data itself. That covers ordering across two unrelated clocks, the exact counts at which the threshold flags change under default and loaded offsets, the fixing of the second pin's role at reset, the masking of the output bus, and the absence of stray words after blocked writes.

// File: rtl/dcfifo_pkg.sv
// Shared types for the dual-clock FIFO.
// Assumes nothing beyond standard SystemVerilog enums.
package dcfifo_pkg;
    // Role of the second write pin, fixed while reset is held
    typedef enum logic {ROLE_ENABLE = 1'b0, ROLE_LOAD = 1'b1} wr2_role_e;
    // Which offset register the next load strobe writes
    typedef enum logic {TGT_EMPTY = 1'b0, TGT_FULL = 1'b1} ofs_tgt_e;
endpackage

// File: rtl/dcfifo_sync.sv
// Two-stage synchronizer for a bus that is either Gray coded or
// quasi-static. It assumes that at most one bit changes per source
// edge, or that the source is held stable for many destination edges.
module dcfifo_sync #(
    parameter int W = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Move the bus into the destination domain through two registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/dcfifo_wr_ctl.sv
// Write-side control. Holds the write pointer, the full and nearly-full
// flags, the role of the second write pin and the two offset registers.
// Assumes rgray_sync is the read pointer already brought into wr_clk.
module dcfifo_wr_ctl
    import dcfifo_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DEF_OFS = 7
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic              wr_en1_n,
    input  logic              wr_en2_ld,
    input  logic [ADDR_W-1:0] ofs_data,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic              mem_we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic [ADDR_W-1:0] empty_ofs,
    output logic              full_n,
    output logic              almost_full_n
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    wr2_role_e        role_q;
    ofs_tgt_e         tgt_q;
    logic [ADDR_W-1:0] full_ofs_q, empty_ofs_q;
    logic [PW-1:0]    wbin_q, wgray_q, rbin_w, wbin_nx, used_nx, free_nx;
    logic             full_n_q, afull_n_q, wr_fire, ld_fire;

    // Convert the synchronized read pointer from Gray to binary
    always_comb begin
        for (int i = 0; i < PW; i++) rbin_w[i] = ^(rgray_sync >> i);
    end

    // Decide on a memory write or an offset load, and compute the next occupancy
    always_comb begin
        wr_fire = !wr_en1_n && wr_en2_ld && full_n_q;
        ld_fire = (role_q == ROLE_LOAD) && !wr_en1_n && !wr_en2_ld;
        wbin_nx = wbin_q + PW'(wr_fire);
        used_nx = wbin_nx - rbin_w;
        free_nx = PW'(DEPTH) - used_nx;
    end

    // Pointer, flags, role capture and offset registers
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            role_q      <= wr_en2_ld ? ROLE_ENABLE : ROLE_LOAD;
            tgt_q       <= TGT_EMPTY;
            empty_ofs_q <= ADDR_W'(DEF_OFS);
            full_ofs_q  <= ADDR_W'(DEF_OFS);
            wbin_q      <= '0;
            wgray_q     <= '0;
            full_n_q    <= 1'b1;
            afull_n_q   <= 1'b1;
        end else begin
            wbin_q    <= wbin_nx;
            wgray_q   <= wbin_nx ^ (wbin_nx >> 1);
            full_n_q  <= (used_nx != PW'(DEPTH));
            afull_n_q <= (free_nx > {1'b0, full_ofs_q});
            if (ld_fire) begin
                if (tgt_q == TGT_EMPTY) empty_ofs_q <= ofs_data;
                else                    full_ofs_q  <= ofs_data;
                tgt_q <= (tgt_q == TGT_EMPTY) ? TGT_FULL : TGT_EMPTY;
            end
        end
    end

    assign mem_we        = wr_fire;
    assign waddr         = wbin_q[ADDR_W-1:0];
    assign wgray         = wgray_q;
    assign empty_ofs     = empty_ofs_q;
    assign full_n        = full_n_q;
    assign almost_full_n = afull_n_q;

    // R6
    full_blocks_write_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n_q |=> $stable(wbin_q));
    // R6
    wr_occupancy_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (PW'(wbin_q - rbin_w) <= PW'(DEPTH)));
    // R6
    wgray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wgray_q ^ $past(wgray_q)) <= 1);
    // R11
    full_implies_afull_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n_q |-> !afull_n_q);
endmodule

// File: rtl/dcfifo_rd_ctl.sv
// Read-side control. Holds the read pointer and the empty and nearly-empty
// flags. Assumes wgray_sync and empty_ofs_sync are already in rd_clk.
module dcfifo_rd_ctl #(
    parameter int ADDR_W = 6
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              rd_en1_n,
    input  logic              rd_en2_n,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic [ADDR_W-1:0] empty_ofs_sync,
    output logic              rd_fire,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic              empty_n,
    output logic              almost_empty_n
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PW-1:0] rbin_q, rgray_q, wbin_r, rbin_nx, used_nx;
    logic          empty_n_q, aempty_n_q;

    // Convert the synchronized write pointer from Gray to binary
    always_comb begin
        for (int i = 0; i < PW; i++) wbin_r[i] = ^(wgray_sync >> i);
    end

    // Accept a read and compute the next occupancy seen from this side
    always_comb begin
        rd_fire = !rd_en1_n && !rd_en2_n && empty_n_q;
        rbin_nx = rbin_q + PW'(rd_fire);
        used_nx = wbin_r - rbin_nx;
    end

    // Read pointer and read-side flags
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rbin_q     <= '0;
            rgray_q    <= '0;
            empty_n_q  <= 1'b0;
            aempty_n_q <= 1'b0;
        end else begin
            rbin_q     <= rbin_nx;
            rgray_q    <= rbin_nx ^ (rbin_nx >> 1);
            empty_n_q  <= (used_nx != '0);
            aempty_n_q <= (used_nx > {1'b0, empty_ofs_sync});
        end
    end

    assign raddr          = rbin_q[ADDR_W-1:0];
    assign rgray          = rgray_q;
    assign empty_n        = empty_n_q;
    assign almost_empty_n = aempty_n_q;

    // R7
    empty_blocks_read_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n_q |=> $stable(rbin_q));
    // R7
    rd_occupancy_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (PW'(wbin_r - rbin_q) <= PW'(DEPTH)));
    // R7
    rgray_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(rgray_q ^ $past(rgray_q)) <= 1);
    // R11
    empty_implies_aempty_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n_q |-> !aempty_n_q);
endmodule

// File: rtl/dcfifo_progflag.sv
// Dual-clock FIFO top. It holds the storage array and the registered
// output, and it connects the two control sides through synchronizers.
// Assumes ADDR_W <= DATA_W, so that an offset fits in one data word.
module dcfifo_progflag #(
    parameter int DATA_W  = 9,
    parameter int ADDR_W  = 6,
    parameter int DEF_OFS = 7
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en1_n,
    input  logic              wr_en2_ld,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en1_n,
    input  logic              rd_en2_n,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              empty_n,
    output logic              full_n,
    output logic              almost_empty_n,
    output logic              almost_full_n
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] dout_q;
    logic              valid_q, mem_we, rd_fire;
    logic [ADDR_W-1:0] waddr, raddr, empty_ofs, empty_ofs_r;
    logic [PW-1:0]     wgray, rgray, wgray_r, rgray_w;

    dcfifo_wr_ctl #(.ADDR_W(ADDR_W), .DEF_OFS(DEF_OFS)) i_wr (
        .wr_clk(wr_clk), .rst_n(rst_n), .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld),
        .ofs_data(wr_data[ADDR_W-1:0]), .rgray_sync(rgray_w), .mem_we(mem_we),
        .waddr(waddr), .wgray(wgray), .empty_ofs(empty_ofs), .full_n(full_n),
        .almost_full_n(almost_full_n));

    dcfifo_rd_ctl #(.ADDR_W(ADDR_W)) i_rd (
        .rd_clk(rd_clk), .rst_n(rst_n), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
        .wgray_sync(wgray_r), .empty_ofs_sync(empty_ofs_r), .rd_fire(rd_fire),
        .raddr(raddr), .rgray(rgray), .empty_n(empty_n),
        .almost_empty_n(almost_empty_n));

    dcfifo_sync #(.W(PW)) i_sync_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_w));
    dcfifo_sync #(.W(PW)) i_sync_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_r));
    dcfifo_sync #(.W(ADDR_W), .RST_VAL(ADDR_W'(DEF_OFS))) i_sync_ofs (
        .clk(rd_clk), .rst_n(rst_n), .d(empty_ofs), .q(empty_ofs_r));

    // Store the accepted word at the write pointer
    always_ff @(posedge wr_clk) begin
        if (mem_we) mem[waddr] <= wr_data;
    end

    // Register the word read from the array and mark it valid for one cycle
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            dout_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= rd_fire;
            if (rd_fire) dout_q <= mem[raddr];
        end
    end

    assign rd_data  = out_en_n ? '0 : dout_q;
    assign rd_valid = valid_q;
endmodule

// File: tb/test_dcfifo_progflag.sv
`timescale 1ns/1ps
module test_dcfifo_progflag;
    localparam int DEPTH = 64;

    logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic wr_en1_n = 1'b1, wr_en2_ld = 1'b1, rd_en1_n = 1'b1, rd_en2_n = 1'b1, out_en_n = 1'b0;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic rd_valid, empty_n, full_n, almost_empty_n, almost_full_n;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [8:0] exp_q[$];

    always #4    wr_clk = ~wr_clk;   // 125 MHz
    always #6.5  rd_clk = ~rd_clk;   // unrelated read clock

    dcfifo_progflag i_dcfifo_progflag (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en1_n(wr_en1_n),
        .wr_en2_ld(wr_en2_ld), .wr_data(wr_data), .rd_en1_n(rd_en1_n),
        .rd_en2_n(rd_en2_n), .out_en_n(out_en_n), .rd_data(rd_data),
        .rd_valid(rd_valid), .empty_n(empty_n), .full_n(full_n),
        .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n));

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_flags(input string req, input int e, input int ae, input int f, input int af);
        chk(req, "empty_n", empty_n, e);
        chk(req, "almost_empty_n", almost_empty_n, ae);
        chk(req, "full_n", full_n, f);
        chk(req, "almost_full_n", almost_full_n, af);
    endtask

    task automatic do_reset(input logic role_pin);
        rst_n = 1'b0; wr_en2_ld = role_pin; wr_en1_n = 1'b1;
        rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        repeat (5) @(negedge rd_clk);
        @(negedge wr_clk);
        rst_n = 1'b1; wr_en2_ld = 1'b1;
        exp_q.delete();
        repeat (2) @(negedge rd_clk);
    endtask

    // Driver: one write attempt; the word is expected only when it should be stored
    task automatic wr_word(input logic [8:0] d, input bit stored);
        @(negedge wr_clk);
        wr_en1_n = 1'b0; wr_en2_ld = 1'b1; wr_data = d;
        @(negedge wr_clk);
        wr_en1_n = 1'b1;
        if (stored) exp_q.push_back(d);
    endtask

    task automatic wr_burst(input int n, input int base);
        for (int i = 0; i < n; i++) wr_word(9'(base + i), 1'b1);
    endtask

    // Strobe the second pin low with enable 1 low (load or blocked write)
    task automatic strobe_low(input logic [8:0] d);
        @(negedge wr_clk);
        wr_en1_n = 1'b0; wr_en2_ld = 1'b0; wr_data = d;
        @(negedge wr_clk);
        wr_en1_n = 1'b1; wr_en2_ld = 1'b1;
    endtask

    task automatic settle();
        repeat (6) @(posedge rd_clk);
        repeat (6) @(posedge wr_clk);
        #1;
    endtask

    task automatic read_one();
        @(negedge rd_clk);
        rd_en1_n = 1'b0; rd_en2_n = 1'b0;
        @(negedge rd_clk);
        rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        chk("R2", "rd_valid after read", rd_valid, 1);
        @(negedge rd_clk);
        chk("R2", "rd_valid one cycle", rd_valid, 0);
    endtask

    task automatic drain();
        @(negedge rd_clk);
        rd_en1_n = 1'b0; rd_en2_n = 1'b0;
        for (int i = 0; i < 4 * DEPTH && exp_q.size() != 0; i++) @(negedge rd_clk);
        repeat (3) @(negedge rd_clk);   // extra attempts on an empty FIFO (R7)
        rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        chk("R1", "words left unread", exp_q.size(), 0);
    endtask

    // Monitor: compare each valid output against the scoreboard queue
    always @(negedge rd_clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R7 unexpected word: actual %0d expected none", rd_data);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                if (out_en_n) begin
                    if (rd_data !== 9'd0) begin
                        errors++;
                        $display("FAIL R10 masked data: actual %0d expected 0", rd_data);
                    end
                end else if (rd_data !== e) begin
                    errors++;
                    $display("FAIL R1 data order: actual %0d expected %0d", rd_data, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge wr_clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] held;
        // Enable-role reset
        do_reset(1'b1);
        chk_flags("R5", 0, 0, 1, 1);
        chk("R5", "rd_valid", rd_valid, 0);
        chk("R5", "rd_data", rd_data, 0);

        wr_burst(7, 9'h100);
        settle();
        chk_flags("R9", 1, 0, 1, 1);          // 7 stored, offset 7
        wr_burst(1, 9'h107);
        settle();
        chk_flags("R9", 1, 1, 1, 1);          // 8 stored

        // R3: second pin low blocks writes in enable role
        strobe_low(9'h155); strobe_low(9'h156); strobe_low(9'h157);
        settle();
        chk_flags("R3", 1, 1, 1, 1);

        // R10: masked read still consumes a word
        held = exp_q[0];
        out_en_n = 1'b1;
        read_one();
        chk("R10", "rd_data masked", rd_data, 0);
        out_en_n = 1'b0;
        #1;
        chk("R10", "held word visible", rd_data, held);
        settle();
        chk_flags("R9", 1, 0, 1, 1);          // back to 7 stored

        // Fill towards full
        wr_burst(49, 9'h010);                 // 56 stored, 8 free
        settle();
        chk_flags("R8", 1, 1, 1, 1);
        wr_burst(1, 9'h041);                  // 57 stored, 7 free
        settle();
        chk_flags("R8", 1, 1, 1, 0);
        wr_burst(7, 9'h042);                  // 64 stored
        settle();
        chk_flags("R6", 1, 1, 0, 0);
        wr_word(9'h1AA, 1'b0);                // write attempt while full
        settle();
        chk_flags("R11", 1, 1, 0, 0);

        drain();                              // R3/R6: no stray words
        settle();
        chk_flags("R7", 0, 0, 1, 1);
        chk("R7", "rd_valid idle", rd_valid, 0);

        // Load-role reset
        do_reset(1'b0);
        chk_flags("R5", 0, 0, 1, 1);
        strobe_low(9'd3);                     // nearly-empty offset
        strobe_low(9'd10);                    // nearly-full offset
        settle();
        chk_flags("R4", 0, 0, 1, 1);          // loads did not store words
        wr_burst(3, 9'h0A0);
        settle();
        chk_flags("R4", 1, 0, 1, 1);
        wr_burst(1, 9'h0A3);
        settle();
        chk_flags("R4", 1, 1, 1, 1);
        wr_burst(49, 9'h0C0);                 // 53 stored, 11 free
        settle();
        chk_flags("R4", 1, 1, 1, 1);
        wr_burst(1, 9'h0F1);                  // 54 stored, 10 free
        settle();
        chk_flags("R4", 1, 1, 1, 0);
        drain();
        settle();
        chk_flags("R7", 0, 0, 1, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule